// File: doc/BRIEF.md
# Register Rename Stage with Physical Register Free List

This block renames the register fields of one instruction per cycle. Architectural register names index a map table. Each entry of the table holds the physical register that carries the newest value of that name. Both source names are looked up combinationally in the same cycle, so every reader sees the mapping left by the most recent earlier writer.

When the instruction writes a register, the block takes a fresh physical register from the head of a FIFO free list. From the next cycle on, the map entry of the destination points at that fresh register. The mapping that was replaced is reported on its own output. Retirement logic hands that mapping back later through the release port, once the last reader of the old value has completed. This removes the false ordering that comes from reusing a few architectural names.

If a writing instruction finds the free list empty, the block holds it back with a ready signal. Instructions that do not write a register are never held back.

Top module: `rn_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free list holds physical registers ARCH_REGS to PHYS_REGS-1 and hands them out in ascending order.
- R2: `ren_psrc1` and `ren_psrc2` show, in the same cycle, the current map entries for `in_src1` and `in_src2`.
- R3: An accepted instruction (`in_valid` and `in_ready` high) with `in_has_dst` high gets the free-list head on `ren_pdst`. From the next cycle on, the map entry of `in_dst` holds that register, so later lookups of `in_dst` return it. The fresh register never equals the mapping it replaces.
- R4: Sources are looked up before the same instruction's destination update. A source equal to `in_dst` returns the old mapping, and `ren_prev_pdst` carries the old mapping of `in_dst`.
- R5: An accepted instruction with `in_has_dst` low allocates nothing and leaves the map unchanged.
- R6: When the free list is empty, `in_ready` is low while `in_has_dst` is high. `in_ready` stays high for instructions without a destination.
- R7: A release (`rel_valid` high) appends `rel_preg` to the tail of the free list. It can be allocated from the next cycle on, after every register already queued. A release does not lift a stall in the cycle it arrives.
- R8: While `in_valid` is low, neither the map nor the free list changes.
- R9: A release and an allocation in the same cycle both take effect, and the free-list occupancy stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered for renaming |
| in_ready | output | 1 | The offered instruction can be accepted this cycle |
| in_src1 | input | $clog2(ARCH_REGS) | First architectural source |
| in_src2 | input | $clog2(ARCH_REGS) | Second architectural source |
| in_has_dst | input | 1 | The instruction writes a register |
| in_dst | input | $clog2(ARCH_REGS) | Architectural destination |
| ren_psrc1 | output | $clog2(PHYS_REGS) | Physical register for the first source |
| ren_psrc2 | output | $clog2(PHYS_REGS) | Physical register for the second source |
| ren_pdst | output | $clog2(PHYS_REGS) | Fresh physical register for the destination |
| ren_prev_pdst | output | $clog2(PHYS_REGS) | Mapping of the destination being replaced |
| rel_valid | input | 1 | Return a physical register to the free list |
| rel_preg | input | $clog2(PHYS_REGS) | Physical register being returned |

## Verification
The assertions assume that release traffic is legal. A register is returned only after it has been displaced from the map, and only once. Under that assumption the free list can never be pushed while full unless an allocation pops it in the same cycle. The bench keeps to this by returning only mappings that the block itself reported on `ren_prev_pdst`, oldest first, and each one exactly once. In this way the random mix of allocations, lookups and releases stays within what retirement logic could produce.

// File: rtl/rn_pkg.sv
package rn_pkg;
    parameter int unsigned RN_ARCH_REGS = 8;
    parameter int unsigned RN_PHYS_REGS = 16;

    // free-list operation selected from {push, pop}
    typedef enum logic [1:0] {
        FL_IDLE = 2'b00,
        FL_POP  = 2'b01,
        FL_PUSH = 2'b10,
        FL_BOTH = 2'b11
    } fl_op_e;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int unsigned ARCH = 8,
    parameter int unsigned PHYS = 16,
    localparam int unsigned AW = $clog2(ARCH),
    localparam int unsigned PW = $clog2(PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a_idx,
    input  logic [AW-1:0] rd_b_idx,
    input  logic [AW-1:0] rd_c_idx,
    output logic [PW-1:0] rd_a_phys,
    output logic [PW-1:0] rd_b_phys,
    output logic [PW-1:0] rd_c_phys,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [PW-1:0] wr_phys
);
    typedef struct packed {
        logic [ARCH-1:0][PW-1:0] ent;
    } map_state_t;

    map_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.ent[wr_idx] = wr_phys;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(ARCH); i++) begin
                state_q.ent[i] <= PW'(i);
            end
        end else begin
            state_q <= state_d;
        end
    end

    // reads see the table before this cycle's write
    assign rd_a_phys = state_q.ent[rd_a_idx];
    assign rd_b_phys = state_q.ent[rd_b_idx];
    assign rd_c_phys = state_q.ent[rd_c_idx];
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
    parameter int unsigned ARCH = 8,
    parameter int unsigned PHYS = 16,
    localparam int unsigned DEPTH = PHYS - ARCH,
    localparam int unsigned IW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1),
    localparam int unsigned PW = $clog2(PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [PW-1:0] push_phys,
    output logic [PW-1:0] head_phys,
    output logic [CW-1:0] count
);
    import rn_pkg::*;

    typedef struct packed {
        logic [DEPTH-1:0][PW-1:0] slot;
        logic [IW-1:0]            rd;
        logic [IW-1:0]            wr;
        logic [CW-1:0]            cnt;
    } fl_state_t;

    fl_state_t state_d, state_q;
    fl_op_e    op;

    function automatic logic [IW-1:0] step_ptr(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        state_d = state_q;
        op      = fl_op_e'({push, pop});
        case (op)
            FL_POP: begin
                state_d.rd  = step_ptr(state_q.rd);
                state_d.cnt = state_q.cnt - 1'b1;
            end
            FL_PUSH: begin
                state_d.slot[state_q.wr] = push_phys;
                state_d.wr  = step_ptr(state_q.wr);
                state_d.cnt = state_q.cnt + 1'b1;
            end
            FL_BOTH: begin
                state_d.slot[state_q.wr] = push_phys;
                state_d.wr = step_ptr(state_q.wr);
                state_d.rd = step_ptr(state_q.rd);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < int'(DEPTH); k++) begin
                state_q.slot[k] <= PW'(ARCH + k);
            end
            state_q.rd  <= '0;
            state_q.wr  <= '0;
            state_q.cnt <= CW'(DEPTH);
        end else begin
            state_q <= state_d;
        end
    end

    assign head_phys = state_q.slot[state_q.rd];
    assign count     = state_q.cnt;
endmodule

// File: rtl/rn_rename.sv
module rn_rename #(
    parameter int unsigned ARCH_REGS = rn_pkg::RN_ARCH_REGS,
    parameter int unsigned PHYS_REGS = rn_pkg::RN_PHYS_REGS,
    localparam int unsigned AW = $clog2(ARCH_REGS),
    localparam int unsigned PW = $clog2(PHYS_REGS),
    localparam int unsigned DEPTH = PHYS_REGS - ARCH_REGS,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [AW-1:0] in_src1,
    input  logic [AW-1:0] in_src2,
    input  logic          in_has_dst,
    input  logic [AW-1:0] in_dst,
    output logic [PW-1:0] ren_psrc1,
    output logic [PW-1:0] ren_psrc2,
    output logic [PW-1:0] ren_pdst,
    output logic [PW-1:0] ren_prev_pdst,
    input  logic          rel_valid,
    input  logic [PW-1:0] rel_preg
);
    logic [CW-1:0] free_cnt;
    logic [PW-1:0] free_head;
    logic          take;

    // stall decision uses registered occupancy only: no release bypass
    assign in_ready = !in_has_dst || (free_cnt != '0);
    assign take     = in_valid && in_ready && in_has_dst;
    assign ren_pdst = free_head;

    rn_map_table #(.ARCH(ARCH_REGS), .PHYS(PHYS_REGS)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (in_src1),
        .rd_b_idx  (in_src2),
        .rd_c_idx  (in_dst),
        .rd_a_phys (ren_psrc1),
        .rd_b_phys (ren_psrc2),
        .rd_c_phys (ren_prev_pdst),
        .wr_en     (take),
        .wr_idx    (in_dst),
        .wr_phys   (free_head)
    );

    rn_free_list #(.ARCH(ARCH_REGS), .PHYS(PHYS_REGS)) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop       (take),
        .push      (rel_valid),
        .push_phys (rel_preg),
        .head_phys (free_head),
        .count     (free_cnt)
    );
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
    parameter int unsigned ARCH_REGS = 8,
    parameter int unsigned PHYS_REGS = 16,
    localparam int unsigned AW = $clog2(ARCH_REGS),
    localparam int unsigned PW = $clog2(PHYS_REGS),
    localparam int unsigned DEPTH = PHYS_REGS - ARCH_REGS,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic [AW-1:0] in_src1,
    input logic          in_has_dst,
    input logic [AW-1:0] in_dst,
    input logic [PW-1:0] ren_psrc1,
    input logic [PW-1:0] ren_pdst,
    input logic [PW-1:0] ren_prev_pdst,
    input logic          rel_valid,
    input logic [CW-1:0] free_cnt
);
    logic alloc;
    assign alloc = in_valid && in_ready && in_has_dst;

    assert_next_lookup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |=> ((in_src1 != $past(in_dst)) || (ren_psrc1 == $past(ren_pdst))));

    assert_fresh_differs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (ren_pdst != ren_prev_pdst));

    assert_no_alloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc |=> (free_cnt == $past(free_cnt) + CW'($past(rel_valid))));

    assert_stall_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_has_dst && free_cnt == '0) |-> !in_ready);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> ((free_cnt < CW'(DEPTH)) || alloc));

    assert_swap_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && rel_valid) |=> $stable(free_cnt));
endmodule

bind rn_rename rn_rename_chk #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_chk (.*);

// File: tb/sim_rn_rename.sv
`timescale 1ns/1ps
module sim_rn_rename;
    localparam int ARCH = 8;
    localparam int PHYS = 16;
    localparam int AW = $clog2(ARCH);
    localparam int PW = $clog2(PHYS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_has_dst = 1'b0, rel_valid = 1'b0;
    logic [AW-1:0] in_src1 = '0, in_src2 = '0, in_dst = '0;
    logic [PW-1:0] rel_preg = '0;
    logic in_ready;
    logic [PW-1:0] ren_psrc1, ren_psrc2, ren_pdst, ren_prev_pdst;

    rn_rename #(.ARCH_REGS(ARCH), .PHYS_REGS(PHYS)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_src1(in_src1), .in_src2(in_src2), .in_has_dst(in_has_dst),
        .in_dst(in_dst), .ren_psrc1(ren_psrc1), .ren_psrc2(ren_psrc2),
        .ren_pdst(ren_pdst), .ren_prev_pdst(ren_prev_pdst),
        .rel_valid(rel_valid), .rel_preg(rel_preg)
    );

    always #10 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int m_map[ARCH];
    int fl[PHYS];
    int fl_n;
    int pend[PHYS];
    int pend_n;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < ARCH; i++) m_map[i] = i;
        for (int k = 0; k < PHYS - ARCH; k++) fl[k] = ARCH + k;
        fl_n = PHYS - ARCH;
        pend_n = 0;
    endtask

    // one cycle: drive at negedge, check combinational outputs, update model at posedge
    task automatic drive(input int v, input int s1, input int s2, input int hd,
                         input int d, input int rv, input int rp, input string tag);
        bit exp_ready;
        @(negedge clk);
        in_valid = v[0]; in_src1 = AW'(s1); in_src2 = AW'(s2);
        in_has_dst = hd[0]; in_dst = AW'(d); rel_valid = rv[0]; rel_preg = PW'(rp);
        #1;
        exp_ready = (hd == 0) || (fl_n > 0);
        chk({"R2 src1 ", tag}, int'(ren_psrc1), m_map[s1]);
        chk({"R2 src2 ", tag}, int'(ren_psrc2), m_map[s2]);
        chk({"R6 ready ", tag}, int'(in_ready), int'(exp_ready));
        if (v != 0 && hd != 0 && exp_ready) begin
            chk({"R3 pdst ", tag}, int'(ren_pdst), fl[0]);
            chk({"R4 prev ", tag}, int'(ren_prev_pdst), m_map[d]);
        end
        @(posedge clk);
        if (v != 0 && hd != 0 && exp_ready) begin
            pend[pend_n] = m_map[d];
            pend_n++;
            m_map[d] = fl[0];
            for (int k = 0; k < PHYS - 1; k++) fl[k] = fl[k+1];
            fl_n--;
        end
        if (rv != 0) begin
            fl[fl_n] = rp;
            fl_n++;
        end
    endtask

    function automatic int take_pend();
        int r = pend[0];
        for (int k = 0; k < PHYS - 1; k++) pend[k] = pend[k+1];
        pend_n--;
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int rp;
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: identity map and first free register after reset
        for (int i = 0; i < ARCH; i++) drive(0, i, (i + 1) % ARCH, 0, 0, 0, 0, "R1 reset map");
        #1 chk("R1 free head", int'(ren_pdst), ARCH);

        // R8: a write offered with in_valid low changes nothing
        drive(0, 3, 3, 1, 3, 0, 0, "R8 idle write");
        drive(0, 3, 0, 0, 0, 0, 0, "R8 after idle");
        #1 chk("R8 head unchanged", int'(ren_pdst), ARCH);

        // five-instruction sequence writing R2 twice
        drive(1, 3, 4, 1, 2, 0, 0, "seq add r2");
        drive(1, 2, 1, 0, 0, 0, 0, "R5 seq store");
        drive(1, 1, 1, 1, 1, 0, 0, "R4 seq r1 self");
        drive(1, 5, 6, 1, 2, 0, 0, "seq add r2 again");
        drive(1, 2, 1, 0, 0, 0, 0, "R5 seq store 2");
        drive(0, 2, 1, 0, 0, 0, 0, "seq readback");
        #1;
        chk("R3 seq r2 mapping", int'(ren_psrc1), ARCH + 2);
        chk("R3 seq r1 mapping", int'(ren_psrc2), ARCH + 1);

        // R6: drain free list, then stall only writers
        while (fl_n > 0) drive(1, 0, 0, 1, 7, 0, 0, "R6 drain");
        drive(1, 0, 0, 1, 5, 0, 0, "R6 empty stall");
        drive(1, 5, 5, 0, 0, 0, 0, "R6 nodst passes");
        // R7: release does not lift the stall in its own cycle
        rp = take_pend();
        drive(1, 4, 4, 1, 4, 1, rp, "R7 no bypass");
        drive(1, 4, 4, 1, 4, 0, 0, "R7 reuse released");
        #1 chk("R7 released reg mapped", int'(ren_psrc1), rp);

        // constrained random traffic with legal releases
        for (int n = 0; n < 600; n++) begin
            int v  = ($urandom % 4) != 0;
            int hd = ($urandom % 10) < 7;
            int rv = (pend_n > 0) && (($urandom % 3) == 0);
            int r  = 0;
            if (rv != 0) r = take_pend();
            drive(v, $urandom % ARCH, $urandom % ARCH, hd, $urandom % ARCH, rv, r,
                  "R9 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule